// File: doc/BRIEF.md
# Dual-Section Ripple Binary Counter

This block is a four-stage binary counter made of toggle stages. It is split into two sections. The low section is a single divide-by-two stage. The high section is a three-stage ripple chain that divides by eight. Each section has its own count-pulse input, and every stage changes state on the falling edge of its clock. Inside the high section, each stage is clocked by the falling output of the stage below it. The outputs therefore settle one after another rather than together, so combinations decoded from them can glitch and must not be used as clocks.

A clear input pair acts as an AND: the counter is cleared only while both inputs are high. While that condition holds, all stages are forced to zero without regard to either clock. Counting starts again on the first falling edge that arrives after the clear is released.

The low stage can run on its own, as long as it is cleared together with the high section. It can also be cascaded into a 4-bit counter. This is done either by routing bit 0 of the output back to the high-section pulse input outside the block, or by setting the `LINK` parameter to `LINK_INTERNAL`. In that mode the high-section pulse input is ignored. The width of the high section is set by the `HI_STAGES` parameter.

Top module: `rc_dual_counter`

## Requirements
- R1: While `clr_a_i` and `clr_b_i` are both 1, `q_o` is all zeros, and falling edges on either pulse input leave it at zero.
- R2: Bit 0 of `q_o` inverts on every falling edge of `pulse_a_i` and does not change on a rising edge.
- R3: With `LINK_EXTERNAL` and `pulse_b_i` driven on its own, edges on `pulse_a_i` leave bits 3..1 unchanged.
- R4: Bits 3..1 of `q_o` form a binary count with bit 1 as LSB. Bit k inverts on the falling edge of bit k-1, so N falling edges on the high-section clock give N mod 8, and the count wraps from 7 to 0.
- R5: With only one of `clr_a_i`/`clr_b_i` high, counting goes on exactly as if neither were high.
- R6: After the clear is released, the first falling edge of a pulse input that occurs after the release advances the count. A pulse input that is already high when the clear is released produces no count until it falls.
- R7: With `LINK_EXTERNAL` and bit 0 of `q_o` wired to `pulse_b_i`, N falling edges on `pulse_a_i` give `q_o` = N mod 16.
- R8: With `LINK_INTERNAL`, N falling edges on `pulse_a_i` give `q_o` = N mod 16, and edges on `pulse_b_i` have no effect.
- R9: Raising both clear inputs at any count value forces `q_o` to zero at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pulse_a_i | input | 1 | Count pulses for the low stage; falling edge active |
| pulse_b_i | input | 1 | Count pulses for the high section; falling edge active; ignored with LINK_INTERNAL |
| clr_a_i | input | 1 | Clear request, first half of the AND pair |
| clr_b_i | input | 1 | Clear request, second half of the AND pair |
| q_o | output | HI_STAGES+1 | Stage states; bit 0 is the low stage, bits above are the high section |

## Verification
The properties are sampled on the falling edges of the count clocks. They assume that the clear pair never changes in the same instant as a falling count edge, and that the clear is asserted once before the first count edge. The stimulus changes at most one kind of input per step, and it raises the clear before any pulse activity. Every release of the clear and every change of the link wiring happens in its own step, apart from any count edge.

// File: rtl/ripple_ctr_pkg.sv
package ripple_ctr_pkg;

    // How the high section obtains its count clock.
    typedef enum logic {
        LINK_EXTERNAL = 1'b0,
        LINK_INTERNAL = 1'b1
    } link_mode_e;

    // State held by a single toggle stage.
    typedef struct packed {
        logic level;
    } stage_state_t;

endpackage

// File: rtl/rc_clear_gate.sv
module rc_clear_gate #(
    parameter int N_IN = 2
) (
    input  logic [N_IN-1:0] req_i,
    output logic            clr_o
);
    // Clearing needs every request line high at once.
    assign clr_o = &req_i;
endmodule

// File: rtl/rc_toggle_stage.sv
module rc_toggle_stage
    import ripple_ctr_pkg::*;
(
    input  logic clk_n_i,
    input  logic clr_i,
    output logic q_o
);
    stage_state_t st_d;
    stage_state_t st_q;

    always_comb begin
        st_d       = st_q;
        st_d.level = ~st_q.level;
    end

    // Falling-edge stage with an asynchronous clear that has priority.
    always_ff @(negedge clk_n_i or posedge clr_i) begin
        if (clr_i) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign q_o = st_q.level;
endmodule

// File: rtl/rc_ripple_chain.sv
module rc_ripple_chain #(
    parameter int STAGES = 3
) (
    input  logic              clk_n_i,
    input  logic              clr_i,
    output logic [STAGES-1:0] q_o
);
    logic [STAGES-1:0] stage_clk;

    for (genvar k = 0; k < STAGES; k++) begin : g_stage
        if (k == 0) begin : g_head
            assign stage_clk[k] = clk_n_i;
        end else begin : g_link
            // Each stage is clocked by the falling output of the one below.
            assign stage_clk[k] = q_o[k-1];
        end

        rc_toggle_stage u_stage (
            .clk_n_i (stage_clk[k]),
            .clr_i   (clr_i),
            .q_o     (q_o[k])
        );
    end
endmodule

// File: rtl/rc_dual_counter.sv
module rc_dual_counter
    import ripple_ctr_pkg::*;
#(
    parameter int         HI_STAGES = 3,
    parameter link_mode_e LINK      = LINK_EXTERNAL
) (
    input  logic                 pulse_a_i,
    input  logic                 pulse_b_i,
    input  logic                 clr_a_i,
    input  logic                 clr_b_i,
    output logic [HI_STAGES:0]   q_o
);
    localparam int TOTAL = HI_STAGES + 1;

    logic                 clr_w;
    logic                 hi_clk_w;
    logic [0:0]           lo_q;
    logic [HI_STAGES-1:0] hi_q;

    rc_clear_gate #(.N_IN(2)) u_clear (
        .req_i ({clr_b_i, clr_a_i}),
        .clr_o (clr_w)
    );

    rc_ripple_chain #(.STAGES(1)) u_low (
        .clk_n_i (pulse_a_i),
        .clr_i   (clr_w),
        .q_o     (lo_q)
    );

    if (LINK == LINK_INTERNAL) begin : g_internal
        logic unused_pulse_b;
        assign unused_pulse_b = pulse_b_i;
        assign hi_clk_w       = lo_q[0];
    end else begin : g_external
        assign hi_clk_w = pulse_b_i;
    end

    rc_ripple_chain #(.STAGES(HI_STAGES)) u_high (
        .clk_n_i (hi_clk_w),
        .clr_i   (clr_w),
        .q_o     (hi_q)
    );

    assign q_o[TOTAL-1:0] = {hi_q, lo_q};
endmodule

// File: rtl/rc_dual_counter_chk.sv
module rc_dual_counter_chk
    import ripple_ctr_pkg::*;
#(
    parameter int         HI_STAGES = 3,
    parameter link_mode_e LINK      = LINK_EXTERNAL
) (
    input logic               pulse_a_i,
    input logic               pulse_b_i,
    input logic               clr_a_i,
    input logic               clr_b_i,
    input logic [HI_STAGES:0] q_o
);
    logic clr_all;
    logic hi_clk;
    logic armed_a;
    logic armed_b;

    assign clr_all = clr_a_i & clr_b_i;

    if (LINK == LINK_INTERNAL) begin : g_int
        logic unused_pb;
        assign unused_pb = pulse_b_i;
        assign hi_clk    = q_o[0];
    end else begin : g_ext
        assign hi_clk = pulse_b_i;
    end

    // Set once an edge has been seen since the last clear.
    always_ff @(negedge pulse_a_i or posedge clr_all) begin
        if (clr_all) armed_a <= 1'b0;
        else         armed_a <= 1'b1;
    end

    always_ff @(negedge hi_clk or posedge clr_all) begin
        if (clr_all) armed_b <= 1'b0;
        else         armed_b <= 1'b1;
    end

    // R2: the low stage alternates between consecutive falling edges.
    a_r2_low_alternates: assert property (@(negedge pulse_a_i) disable iff (clr_all)
        armed_a |-> (q_o[0] != $past(q_o[0])));

    // R4: the high section advances by one between consecutive clock edges.
    a_r4_high_increments: assert property (@(negedge hi_clk) disable iff (clr_all)
        armed_b |-> (q_o[HI_STAGES:1] == HI_STAGES'($past(q_o[HI_STAGES:1]) + 1'b1)));

    // R1: a held clear keeps the outputs at zero whatever the low clock does.
    a_r1_clear_holds_low: assert property (@(negedge pulse_a_i) disable iff (!clr_all)
        (q_o == '0));

    // R1: a held clear keeps the outputs at zero whatever the high clock does.
    a_r1_clear_holds_high: assert property (@(negedge pulse_b_i) disable iff (!clr_all)
        (q_o == '0));
endmodule

bind rc_dual_counter rc_dual_counter_chk #(
    .HI_STAGES (HI_STAGES),
    .LINK      (LINK)
) u_chk (
    .pulse_a_i (pulse_a_i),
    .pulse_b_i (pulse_b_i),
    .clr_a_i   (clr_a_i),
    .clr_b_i   (clr_b_i),
    .q_o       (q_o)
);

// File: tb/rc_dual_counter_tb_top.sv
module rc_dual_counter_tb_top;
    import ripple_ctr_pkg::*;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic pa = 1'b0;
    logic pb = 1'b0;
    logic ca = 1'b0;
    logic cb = 1'b0;
    logic ext_link = 1'b0;
    logic checking = 1'b0;
    logic done = 1'b0;

    logic [3:0] q_split;
    logic [3:0] q_casc;
    logic       pb_split;

    assign pb_split = ext_link ? q_split[0] : pb;

    rc_dual_counter #(.HI_STAGES(3), .LINK(LINK_EXTERNAL)) dut_i (
        .pulse_a_i (pa),
        .pulse_b_i (pb_split),
        .clr_a_i   (ca),
        .clr_b_i   (cb),
        .q_o       (q_split)
    );

    rc_dual_counter #(.HI_STAGES(3), .LINK(LINK_INTERNAL)) dut_casc_i (
        .pulse_a_i (pa),
        .pulse_b_i (pb),
        .clr_a_i   (ca),
        .clr_b_i   (cb),
        .q_o       (q_casc)
    );

    // Behavioural reference: plain counters.
    int    m_lo = 0;
    int    m_hi = 0;
    int    c_lo = 0;
    int    c_hi = 0;
    int    n_vec = 0;
    int    n_bad = 0;
    string cur_req = "R1";

    task automatic apply(input logic a, input logic b, input logic c1, input logic c2);
        @(posedge clk);
        if (c1 && c2) begin
            m_lo = 0; m_hi = 0; c_lo = 0; c_hi = 0;
        end else begin
            if (pa && !a) begin
                if (ext_link && m_lo == 1) m_hi = (m_hi + 1) % 8;
                m_lo = 1 - m_lo;
                if (c_lo == 1) c_hi = (c_hi + 1) % 8;
                c_lo = 1 - c_lo;
            end
            if (pb && !b && !ext_link) m_hi = (m_hi + 1) % 8;
        end
        pa = a; pb = b; ca = c1; cb = c2;
    endtask

    task automatic pulse_a(input int n);
        for (int i = 0; i < n; i++) begin
            apply(1'b1, pb, ca, cb);
            apply(1'b0, pb, ca, cb);
        end
    endtask

    task automatic pulse_b(input int n);
        for (int i = 0; i < n; i++) begin
            apply(pa, 1'b1, ca, cb);
            apply(pa, 1'b0, ca, cb);
        end
    endtask

    always @(negedge clk) begin
        if (checking && !done) begin
            logic [3:0] exp_s;
            logic [3:0] exp_c;
            exp_s = 4'((m_hi << 1) | m_lo);
            exp_c = 4'((c_hi << 1) | c_lo);
            n_vec++;
            if (q_split !== exp_s) begin
                n_bad++;
                $display("FAIL %s split: q=%b expected %b", cur_req, q_split, exp_s);
            end
            n_vec++;
            if (q_casc !== exp_c) begin
                n_bad++;
                $display("FAIL %s linked: q=%b expected %b", cur_req, q_casc, exp_c);
            end
        end
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: run did not complete, expected completion");
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        // R1: reset state, then edges while the clear is held
        cur_req = "R1";
        apply(1'b0, 1'b0, 1'b1, 1'b1);
        checking = 1'b1;
        apply(1'b0, 1'b0, 1'b1, 1'b1);
        pulse_a(3);
        pulse_b(3);

        // R6: pulse input already high at release gives no count until it falls
        cur_req = "R6";
        apply(1'b1, 1'b1, 1'b1, 1'b1);
        apply(1'b1, 1'b1, 1'b0, 1'b0);
        apply(1'b1, 1'b1, 1'b0, 1'b0);
        apply(1'b0, 1'b1, 1'b0, 1'b0);
        apply(1'b0, 1'b0, 1'b0, 1'b0);

        // R2/R3: rising edges do nothing, falling edges toggle bit 0 only
        cur_req = "R2/R3";
        apply(1'b1, 1'b0, 1'b0, 1'b0);
        apply(1'b1, 1'b0, 1'b0, 1'b0);
        pulse_a(5);

        // R4: high section counts, wraps past 7
        cur_req = "R4";
        pulse_b(11);
        pulse_b(5);

        // R5: a single clear input has no effect
        cur_req = "R5";
        apply(pa, pb, 1'b1, 1'b0);
        pulse_a(3);
        pulse_b(6);
        apply(pa, pb, 1'b0, 1'b1);
        pulse_a(2);
        pulse_b(3);
        apply(pa, pb, 1'b0, 1'b0);

        // R9: clear mid-count
        cur_req = "R9";
        apply(pa, pb, 1'b1, 1'b1);
        apply(pa, pb, 1'b1, 1'b1);

        // R7/R8: cascaded 4-bit counting, external wiring and internal link
        cur_req = "R7/R8";
        ext_link = 1'b1;
        apply(1'b0, 1'b0, 1'b1, 1'b1);
        apply(1'b0, 1'b0, 1'b0, 1'b0);
        pulse_a(37);
        // R8: edges on pulse_b do not disturb the internally linked counter
        pulse_b(6);
        pulse_a(20);

        apply(pa, pb, ca, cb);
        @(posedge clk);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule